// File: doc/BRIEF.md
# Three-Channel Capture/Compare Timer

This block is a 16-bit counter shared by three channels. Each channel is set to capture or to compare. The counter can be stopped, or it can count free-running, modulo a period, or up and down. A capture channel records the count when one of two things happens: a rising edge on its input pin, which passes through a synchronizer first, or a one-cycle event strobe. The channel's select bit picks which of the two it uses. A compare channel drives an output bit that is set, cleared or toggled when the count matches. Some of these modes also use the counter's zero or period point, which gives edge-aligned and centre-aligned PWM.

Software programs the block through a byte-wide write port. Compare values are loaded in two writes: the low byte goes into a holding buffer, and the write of the high byte commits the whole value. Whether that value applies at once or waits for the counter to reach zero depends on the channel's output mode. Each channel has a sticky flag and a mask bit. The masked flags are ORed into a combined flag, and a global enable gates that flag onto the interrupt request.

Top module: `cct_timer`

Write map: address 0 is the control register. Its bits [1:0] set the count mode (0 stop, 1 free-running, 2 modulo, 3 up/down), bit 2 is the global interrupt enable, and writing bit 3 as 1 clears the counter to zero and resets the direction to up. Address 1 clears flags: a 0 in bit n clears the flag of channel n. Each channel n has three addresses:

- 4+4n is its configuration: bits [2:0] output mode, bit 3 compare (1) or capture (0), bit 4 event select, bit 5 mask.
- 5+4n is the low byte of its value.
- 6+4n is the high byte of its value.

## Requirements
- R1: After reset the count, outputs and flags are 0. In mode 1 the count increments and wraps from all-ones to 0. In mode 2 it wraps to 0 after reaching channel 0's value. In mode 3 it climbs to channel 0's value and then descends to 0. In mode 0 it holds. With a period of 0, modes 2 and 3 stay at 0.
- R2: A write to a channel's low-byte address leaves the channel value unchanged. The next high-byte write combines its data with the buffered low byte, and a later high-byte write with no new low-byte write reuses the same low byte.
- R3: When the output mode is 0, 1 or 2, a high-byte write loads the new value on that same clock edge.
- R4: In output modes 3 to 7, the value from a high-byte write is held pending. It is loaded on the first edge at which the count is 0x0000.
- R5: In compare mode, the output changes on the clock edge after the cycle in which the count equals the channel value. Mode 0 sets the output, mode 1 clears it, and mode 2 toggles it. Mode 7 drives the output to 0.
- R6: In mode 5, channels 1 and 2 set the output on a match and clear it at the period point. Mode 6 is the inverse: it clears on a match and sets at the period point. The period point is channel 0's value in modulo mode, and all-ones in free-running mode. With period 9 and value 3, the output is high for 6 of every 10 cycles in mode 5 and for 4 in mode 6.
- R7: Mode 3 sets the output on a match while counting up and clears it when the count is 0. Mode 4 is the inverse. In up/down mode with period 8 and value 3, the output is high for 13 of every 16 cycles in mode 3 and for 3 in mode 4.
- R8: Channel 0's output holds its value when channel 0 is in output mode 5 or 6.
- R9: A compare match sets the channel flag, and so does a capture. The exception is channel 0 in up/down mode: its flag is set when the count is 0, not on a match.
- R10: Writing 0 to a flag bit clears that flag. A hardware set in the same cycle wins.
- R11: The combined flag is the OR of the flags whose mask bit is 1. The interrupt request equals the combined flag AND the global enable.
- R12: A channel in pin capture mode passes its input through two synchronizer flops. It loads the count on the third clock edge after the input rises. In this mode the event strobe has no effect.
- R13: A channel with event select set loads the count present during the cycle the strobe is high, on the next edge. A channel in compare mode ignores the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| cap_in | input | NCH | Asynchronous capture pins, one per channel |
| evt_in | input | NCH | Event capture strobes, one per channel |
| count | output | CNT_W | Current counter value |
| ch_value | output | NCH*CNT_W | Value register of each channel (compare value or captured count), channel n at bits n*CNT_W upward |
| ch_out | output | NCH | Compare outputs |
| flags | output | NCH | Sticky channel flags |
| t_flag | output | 1 | OR of the masked flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 10, NCH = 3 and ADDR_W = 4. The narrow counter brings the free-running wrap from all-ones back to zero within about a thousand cycles, so that wrap is checked directly rather than left untried. A 10-bit value still needs both bytes, so the low-byte buffering and the high-byte commit behave exactly as they do at full width. Short periods of 9 and 8 let each PWM duty measurement cover a complete modulo or up/down cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    CM_STOP = 2'd0,
    CM_FREE = 2'd1,
    CM_MOD  = 2'd2,
    CM_UPDN = 2'd3
  } cnt_mode_e;

  typedef enum logic [2:0] {
    OM_SET       = 3'd0,
    OM_CLR       = 3'd1,
    OM_TGL       = 3'd2,
    OM_UPSET_ZCL = 3'd3,
    OM_UPCLR_ZST = 3'd4,
    OM_SET_PCLR  = 3'd5,
    OM_CLR_PSET  = 3'd6,
    OM_INIT      = 3'd7
  } out_mode_e;

  // configuration byte bits [5:0]: mask, evsel, cmp, omode[2:0]
  typedef struct packed {
    logic       mask;
    logic       evsel;
    logic       cmp;
    logic [2:0] omode;
  } ch_cfg_t;

  // modes 0..2 load a new compare value immediately
  function automatic logic commits_now(input logic [2:0] m);
    return m <= 3'd2;
  endfunction

  // next compare output from the events seen in this cycle
  function automatic logic out_next(input logic [2:0] m, input logic is_ch0,
                                    input logic cur, input logic match,
                                    input logic upm, input logic zero,
                                    input logic top);
    logic r;
    case (out_mode_e'(m))
      OM_SET:       r = match ? 1'b1 : cur;
      OM_CLR:       r = match ? 1'b0 : cur;
      OM_TGL:       r = match ? ~cur : cur;
      OM_UPSET_ZCL: r = zero ? 1'b0 : (upm ? 1'b1 : cur);
      OM_UPCLR_ZST: r = zero ? 1'b1 : (upm ? 1'b0 : cur);
      OM_SET_PCLR:  r = is_ch0 ? cur : (top ? 1'b0 : (match ? 1'b1 : cur));
      OM_CLR_PSET:  r = is_ch0 ? cur : (top ? 1'b1 : (match ? 1'b0 : cur));
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             up,
  output logic             top_hit
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  assign top_hit = (mode != CM_STOP) &&
                   ((mode == CM_FREE) ? (count == MAXV) : (count == period));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
      up    <= 1'b1;
    end else begin
      case (mode)
        CM_FREE: begin
          count <= count + 1'b1;
          up    <= 1'b1;
        end
        CM_MOD: begin
          count <= (count >= period) ? '0 : count + 1'b1;
          up    <= 1'b1;
        end
        CM_UPDN: begin
          if (period == '0) begin
            count <= '0;
            up    <= 1'b1;
          end else if (up) begin
            if (count >= period) begin
              up    <= 1'b0;
              count <= count - 1'b1;
            end else begin
              count <= count + 1'b1;
            end
          end else begin
            count <= (count == '0) ? '0 : count - 1'b1;
            if (count <= 1) up <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_mod_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_MOD && !clear && count >= period) |=> count == '0);
  assert_free_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_FREE && !clear) |=> count == $past(count) + 1'b1);
  assert_stop_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_STOP && !clear) |=> $stable(count));

endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit IS_CH0 = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             up,
  input  logic             running,
  input  logic             updn,
  input  logic             top_hit,
  input  logic             cap_pin,
  input  logic             evt,
  output logic [CNT_W-1:0] value,
  output logic             out,
  output logic             flag_set,
  output logic             mask
);

  ch_cfg_t          cfg;
  logic [7:0]       lo_buf;
  logic [CNT_W-1:0] pend;
  logic             pend_v;
  logic [2:0]       sync;
  logic [15:0]      wide_val;
  logic [CNT_W-1:0] new_val;

  // named internal events
  logic pin_rise, cap_hit, match, upm, zero_ev, at_zero, pend_load;

  assign wide_val  = {wdata, lo_buf};
  assign new_val   = wide_val[CNT_W-1:0];
  assign pin_rise  = sync[1] & ~sync[2];
  assign cap_hit   = !cfg.cmp && (cfg.evsel ? evt : pin_rise);
  assign at_zero   = (count == '0);
  assign zero_ev   = running && at_zero;
  assign match     = cfg.cmp && running && (count == value);
  assign upm       = match && up;
  assign pend_load = pend_v && at_zero;
  assign flag_set  = cap_hit ||
                     (cfg.cmp && ((IS_CH0 && updn) ? zero_ev : match));
  assign mask      = cfg.mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      lo_buf <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      sync   <= '0;
      value  <= '0;
      out    <= 1'b0;
    end else begin
      sync <= {sync[1:0], cap_pin};
      if (cfg_we) cfg <= ch_cfg_t'(wdata[5:0]);
      if (lo_we) lo_buf <= wdata;
      if (cfg.cmp)
        out <= out_next(cfg.omode, IS_CH0, out, match, upm, zero_ev, top_hit);
      if (cap_hit)
        value <= count;
      else if (hi_we && commits_now(cfg.omode))
        value <= new_val;
      else if (pend_load)
        value <= pend;
      if (hi_we && !commits_now(cfg.omode)) begin
        pend   <= new_val;
        pend_v <= 1'b1;
      end else if (pend_load) begin
        pend_v <= 1'b0;
      end
    end
  end

  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we && !cap_hit && !pend_load) |=> $stable(value));
  assert_imm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && commits_now(cfg.omode) && !cap_hit) |=> value == $past(new_val));
  assert_defer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !commits_now(cfg.omode) && !cap_hit && !pend_load) |=> $stable(value));
  assert_capture_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.cmp |=> $stable(out));
  assert_cap_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> value == $past(count));

  if (IS_CH0) begin : g_ch0
    assert_ch0_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.cmp && (cfg.omode == 3'd5 || cfg.omode == 3'd6)) |=> $stable(out));
  end

endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 3,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [NCH-1:0]       cap_in,
  input  logic [NCH-1:0]       evt_in,
  output logic [CNT_W-1:0]     count,
  output logic [NCH*CNT_W-1:0] ch_value,
  output logic [NCH-1:0]       ch_out,
  output logic [NCH-1:0]       flags,
  output logic                 t_flag,
  output logic                 irq
);

  localparam int A_CTRL = 0;
  localparam int A_FLAG = 1;
  localparam int A_CH   = 4;
  localparam int STRIDE = 4;

  cnt_mode_e                   mode;
  logic                        gen;
  logic                        clear, ctrl_we, flag_we;
  logic                        up, top_hit, running;
  logic [NCH-1:0]              flag_set, mask;
  logic [NCH-1:0][CNT_W-1:0]   vals;

  assign ctrl_we  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign flag_we  = wr_en && (wr_addr == ADDR_W'(A_FLAG));
  assign clear    = ctrl_we && wr_data[3];
  assign running  = (mode != CM_STOP);
  assign ch_value = vals;
  assign t_flag   = |(flags & mask);
  assign irq      = t_flag && gen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= CM_STOP;
      gen   <= 1'b0;
      flags <= '0;
    end else begin
      if (ctrl_we) begin
        mode <= cnt_mode_e'(wr_data[1:0]);
        gen  <= wr_data[2];
      end
      flags <= (flag_we ? (flags & wr_data[NCH-1:0]) : flags) | flag_set;
    end
  end

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clear(clear), .period(vals[0]),
    .count(count), .up(up), .top_hit(top_hit)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic cfg_we, lo_we, hi_we;
    assign cfg_we = wr_en && (wr_addr == ADDR_W'(A_CH + STRIDE*n));
    assign lo_we  = wr_en && (wr_addr == ADDR_W'(A_CH + STRIDE*n + 1));
    assign hi_we  = wr_en && (wr_addr == ADDR_W'(A_CH + STRIDE*n + 2));

    cct_channel #(.CNT_W(CNT_W), .IS_CH0(n == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .lo_we(lo_we), .hi_we(hi_we),
      .wdata(wr_data), .count(count), .up(up), .running(running),
      .updn(mode == CM_UPDN), .top_hit(top_hit), .cap_pin(cap_in[n]),
      .evt(evt_in[n]), .value(vals[n]), .out(ch_out[n]),
      .flag_set(flag_set[n]), .mask(mask[n])
    );

    assert_hw_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[n] |=> flags[n]);
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && !wr_data[n] && !flag_set[n]) |=> !flags[n]);
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[n] && !flag_we) |=> flags[n]);
  end

endmodule

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
  localparam int CNT_W = 10;
  localparam int NCH   = 3;
  localparam int AW    = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_en = 1'b0;
  logic [AW-1:0]        wr_addr = '0;
  logic [7:0]           wr_data = '0;
  logic [NCH-1:0]       cap_in = '0;
  logic [NCH-1:0]       evt_in = '0;
  logic [CNT_W-1:0]     count;
  logic [NCH*CNT_W-1:0] ch_value;
  logic [NCH-1:0]       ch_out, flags;
  logic                 t_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cct_timer #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(AW)) u_cct_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .evt_in(evt_in), .count(count), .ch_value(ch_value),
    .ch_out(ch_out), .flags(flags), .t_flag(t_flag), .irq(irq)
  );

  // {count mode, period, steps after clear, expected count}
  localparam logic [63:0] VEC [0:9] = '{
    {16'd1, 16'd0, 16'd5,    16'd5},
    {16'd1, 16'd0, 16'd1025, 16'd1},
    {16'd2, 16'd3, 16'd4,    16'd0},
    {16'd2, 16'd3, 16'd5,    16'd1},
    {16'd3, 16'd3, 16'd4,    16'd2},
    {16'd3, 16'd3, 16'd6,    16'd0},
    {16'd3, 16'd3, 16'd7,    16'd1},
    {16'd0, 16'd3, 16'd5,    16'd0},
    {16'd2, 16'd0, 16'd3,    16'd0},
    {16'd3, 16'd0, 16'd3,    16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int val(input int n);
    return int'(ch_value[n*CNT_W +: CNT_W]);
  endfunction

  task automatic duty(input int ch, input int settle, input int win, output int hi);
    hi = 0;
    repeat (settle) @(posedge clk);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      hi += int'(ch_out[ch]);
    end
  endtask

  initial begin
    int hi, c, o, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reset count", int'(count), 0);
    check("R1 reset outputs", int'(ch_out), 0);
    check("R1 reset flags", int'(flags), 0);
    check("R11 reset irq", int'(irq), 0);

    // R1 counter modes from the vector table
    wr(4, 8'h08);
    for (int v = 0; v < 10; v++) begin
      wr(5, int'(VEC[v][39:32]));
      wr(6, int'(VEC[v][47:40]));
      wr(0, int'(VEC[v][49:48]) | 8);
      repeat (int'(VEC[v][31:16])) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1 vector %0d count", v), int'(count), int'(VEC[v][15:0]));
    end

    // R2 / R3 buffered low byte, immediate load in mode 0
    wr(0, 8);
    wr(8, 8'h08);
    wr(9, 8'h34);
    check("R2 low byte alone", val(1), 0);
    wr(10, 8'h02);
    check("R3 immediate load", val(1), 'h234);
    wr(10, 8'h01);
    check("R2 low byte reused", val(1), 'h134);

    // R4 deferred load until count is zero
    wr(8, 8'h0D);
    wr(5, 9); wr(6, 0);
    wr(0, 2 | 8);
    repeat (3) @(posedge clk);
    wr(0, 0);
    wr(9, 3); wr(10, 0);
    check("R4 pending while nonzero", val(1), 'h134);
    wr(0, 8);
    check("R4 pending at clear edge", val(1), 'h134);
    @(posedge clk); @(negedge clk);
    check("R4 loaded at zero", val(1), 3);

    // R6 edge-aligned PWM, period 9, duty value 3
    wr(0, 2 | 8);
    duty(1, 20, 10, hi);
    check("R6 mode 5 high cycles", hi, 6);
    wr(8, 8'h0E);
    duty(1, 20, 10, hi);
    check("R6 mode 6 high cycles", hi, 4);

    // R8 channel 0 holds its output in mode 5
    wr(4, 8'h0D);
    o = int'(ch_out[0]);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(ch_out[0]) != o) bad++;
    end
    check("R8 channel 0 output changes", bad, 0);
    wr(4, 8'h08);

    // R5 compare actions
    wr(0, 8);
    wr(8, 8'h0F);
    @(posedge clk); @(negedge clk);
    check("R5 mode 7 drives low", int'(ch_out[1]), 0);
    wr(8, 8'h08);
    wr(1, 0);
    wr(0, 2 | 8);
    repeat (3) @(posedge clk); @(negedge clk);
    check("R5 before match out", int'(ch_out[1]), 0);
    check("R9 before match flag", int'(flags[1]), 0);
    @(posedge clk); @(negedge clk);
    check("R5 set after match", int'(ch_out[1]), 1);
    check("R9 flag on match", int'(flags[1]), 1);
    wr(8, 8'h09);
    repeat (10) @(posedge clk); @(negedge clk);
    check("R5 mode 1 clears", int'(ch_out[1]), 0);
    wr(8, 8'h0A);
    o = int'(ch_out[1]);
    repeat (10) @(posedge clk); @(negedge clk);
    check("R5 mode 2 toggles", int'(ch_out[1]), 1 - o);

    // R7 centre-aligned PWM, period 8, value 3
    wr(8, 8'h0B);
    wr(5, 8); wr(6, 0);
    wr(0, 3 | 8);
    duty(1, 32, 16, hi);
    check("R7 mode 3 high cycles", hi, 13);
    wr(8, 8'h0C);
    duty(1, 32, 16, hi);
    check("R7 mode 4 high cycles", hi, 3);

    // R9 channel 0 in up/down flags at zero only
    wr(0, 3 | 8);
    wr(1, 0);
    repeat (8) @(posedge clk); @(negedge clk);
    check("R9 ch0 no flag at top", int'(flags[0]), 0);
    check("R9 descending count", int'(count), 6);
    repeat (7) @(posedge clk); @(negedge clk);
    check("R9 ch0 flag at zero", int'(flags[0]), 1);

    // R11 masking and global enable
    check("R11 unmasked t_flag", int'(t_flag), 0);
    wr(4, 8'h28);
    check("R11 masked t_flag", int'(t_flag), 1);
    check("R11 irq without enable", int'(irq), 0);
    wr(0, 3 | 4);
    check("R11 irq with enable", int'(irq), 1);

    // R13 / R10 event capture against a simultaneous flag clear
    wr(12, 8'h10);
    wr(0, 1 | 8);
    wr(1, 0);
    @(negedge clk);
    c = int'(count);
    evt_in[2] = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h00;
    @(negedge clk);
    evt_in[2] = 1'b0; wr_en = 1'b0;
    check("R13 event capture value", val(2), c);
    check("R10 hardware set wins", int'(flags[2]), 1);
    wr(1, 8'hFB);
    check("R10 write zero clears", int'(flags[2]), 0);
    @(negedge clk);
    evt_in[1] = 1'b1;
    @(negedge clk);
    evt_in[1] = 1'b0;
    @(negedge clk);
    check("R13 compare channel ignores event", val(1), 3);

    // R12 pin capture latency
    wr(12, 8'h00);
    o = val(2);
    @(negedge clk);
    c = int'(count);
    cap_in[2] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R12 not loaded after two edges", val(2), o);
    @(posedge clk); @(negedge clk);
    check("R12 loaded on third edge", val(2), c + 2);
    check("R9 flag on capture", int'(flags[2]), 1);
    o = val(2);
    evt_in[2] = 1'b1;
    @(negedge clk);
    evt_in[2] = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 strobe ignored in pin mode", val(2), o);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule